// File: doc/BRIEF.md
# Serialized Domain Reset Sequencer

This block owns the reset-control vectors of several partitions. Each partition has up to 32 resettable domains. A control bit at 1 keeps its domain in reset, and a control bit at 0 lets it run. Software reaches the block through a small register interface: a write port with a ready signal and a combinational read port.

When a new target vector is written to a partition's control register, the block never applies the whole word at once. It forms the set of bits that differ from the current vector and walks that set from the lowest index upward, one bit per step. Each step waits for the affected domain to acknowledge before the next bit is touched. The acknowledge is modelled as a fixed latency of `ACK_LAT` cycles. The read-back vector and the per-partition status bit follow only the acknowledged state, so no two domains ever change level in the same cycle.

A busy flag is high while a sequence runs. A write presented during that time is held off by a low ready, and it is applied once ready returns.

Top module: `seq_domain_reset`

## Requirements
- R1: After reset, every control bit of every partition reads 1, status bit 0 of every partition reads 1, busy is 0 and wrReady is 1.
- R2: The control register of partition p sits at byte address 0x40 + 8*p and its status register at 0x140 + 8*p. Any other address reads 0. A write to any address other than a control register changes nothing.
- R3: The bits a control write changes are exactly the current vector XOR the written value. A bit equal in both never toggles, and a cleared control bit is set again when written with 1.
- R4: Changed bits are applied one per step, lowest bit index first.
- R5: A step becomes visible on domainRst and in the read-back exactly ACK_LAT cycles after the previous step, or after the accepting clock edge for the first step.
- R6: No two bits of domainRst change in the same clock cycle.
- R7: busy is 1 while a sequence runs and wrReady is 0 then. A write presented while busy is held and then applied, not dropped.
- R8: Status bit 0 of a partition reads 1 while control bit 0 of that partition is acknowledged as 1. It reads 0 once the release of bit 0 has been acknowledged. All other status bits read 0.
- R9: Write-data bits at positions NUM_DOMAINS and above are ignored and read back as 0.
- R10: A control write equal to the current vector completes at once: busy stays 0 and no domain changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Write request |
| wrAddr | input | ADDR_W | Write byte address |
| wrData | input | DATA_W | Write data |
| wrReady | output | 1 | Write accepted on a clock edge when both wrValid and wrReady are 1 |
| rdAddr | input | ADDR_W | Read byte address |
| rdData | output | DATA_W | Read data, combinational from rdAddr |
| busy | output | 1 | A change sequence is in progress |
| domainRst | output | NUM_PARTS*NUM_DOMAINS | Acknowledged reset level of every domain; partition p occupies bits [p*NUM_DOMAINS +: NUM_DOMAINS] |

## Verification
The bench builds the block with NUM_PARTS=3, NUM_DOMAINS=8 and ACK_LAT=3. With these values a full eight-bit sweep finishes in 24 cycles, so the bench can follow every single step of a full-width release and a full-width set/clear swap. Three partitions let it show that status and control addresses stay separate for a partition index above one. They also show that a write held during one partition's sequence lands on the right vector. The narrow domain count leaves write-data bits above the domain range, so the bench can show they are discarded.

// File: rtl/seq_domain_reset_pkg.sv
package seq_domain_reset_pkg;

  localparam int CTRL_BASE = 'h40;
  localparam int STAT_BASE = 'h140;
  localparam int REG_STRIDE = 8;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_WAIT
  } seqState_t;

  typedef struct packed {
    logic load;
    logic tick;
    logic commit;
  } seqStrobes_t;

endpackage

// File: rtl/seq_domain_reset_dp.sv
module seq_domain_reset_dp
  import seq_domain_reset_pkg::*;
#(
  parameter int NUM_PARTS   = 2,
  parameter int NUM_DOMAINS = 32,
  parameter int ACK_LAT     = 4,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  seqStrobes_t                         st,
  input  logic [ADDR_W-1:0]                   wrAddr,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [ADDR_W-1:0]                   rdAddr,
  output logic [DATA_W-1:0]                   rdData,
  output logic                                wrIsCtrl,
  output logic                                reqDiffers,
  output logic                                ackDue,
  output logic                                lastBit,
  output logic [NUM_PARTS*NUM_DOMAINS-1:0]    domainRst
);

  localparam int PW = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 1;
  localparam int CW = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(ACK_LAT - 1);

  function automatic logic [ADDR_W-1:0] ctrlAddr(input int p);
    return ADDR_W'(CTRL_BASE + REG_STRIDE * p);
  endfunction

  function automatic logic [ADDR_W-1:0] statAddr(input int p);
    return ADDR_W'(STAT_BASE + REG_STRIDE * p);
  endfunction

  logic [NUM_PARTS-1:0][NUM_DOMAINS-1:0] curVec;
  logic [NUM_DOMAINS-1:0] tgtVec;
  logic [NUM_DOMAINS-1:0] reqData;
  logic [NUM_DOMAINS-1:0] pending;
  logic [NUM_DOMAINS-1:0] stepMask;
  logic [PW-1:0]          actPart;
  logic [PW-1:0]          wrPart;
  logic [CW-1:0]          cnt;

  assign reqData = wrData[NUM_DOMAINS-1:0];

  generate
    if (NUM_DOMAINS < DATA_W) begin : g_hi_drop
      logic unusedHi;
      assign unusedHi = ^wrData[DATA_W-1:NUM_DOMAINS];
    end
  endgenerate

  // address decode of the write port
  always_comb begin
    wrIsCtrl = 1'b0;
    wrPart   = '0;
    for (int p = 0; p < NUM_PARTS; p++) begin
      if (wrAddr == ctrlAddr(p)) begin
        wrIsCtrl = 1'b1;
        wrPart   = PW'(p);
      end
    end
  end

  assign reqDiffers = (curVec[wrPart] != reqData);

  // remaining changes of the active partition, lowest one isolated
  assign pending  = curVec[actPart] ^ tgtVec;
  assign stepMask = pending & ((~pending) + NUM_DOMAINS'(1));
  assign lastBit  = ((pending & ~stepMask) == '0);
  assign ackDue   = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curVec  <= '1;
      tgtVec  <= '1;
      actPart <= '0;
      cnt     <= CNT_INIT;
    end else if (st.load) begin
      tgtVec  <= reqData;
      actPart <= wrPart;
      cnt     <= CNT_INIT;
    end else if (st.commit) begin
      curVec[actPart] <= curVec[actPart] ^ stepMask;
      cnt             <= CNT_INIT;
    end else if (st.tick) begin
      cnt <= cnt - 1'b1;
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PARTS; p++) begin
      if (rdAddr == ctrlAddr(p)) begin
        rdData[NUM_DOMAINS-1:0] = curVec[p];
      end else if (rdAddr == statAddr(p)) begin
        rdData[0] = curVec[p][0];
      end
    end
  end

  assign domainRst = curVec;

  // R5
  ack_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> (cnt == '0));

  // R4
  step_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> ($past(stepMask) & curVec[$past(actPart)]) ==
                  ($past(stepMask) & $past(tgtVec)));

endmodule

// File: rtl/seq_domain_reset_ctl.sv
module seq_domain_reset_ctl
  import seq_domain_reset_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        wrIsCtrl,
  input  logic        reqDiffers,
  input  logic        ackDue,
  input  logic        lastBit,
  output seqStrobes_t st,
  output logic        busy,
  output logic        wrReady
);

  seqState_t state, nextState;

  always_comb begin
    st        = '0;
    nextState = state;
    case (state)
      SEQ_IDLE: begin
        if (wrValid && wrIsCtrl && reqDiffers) begin
          st.load   = 1'b1;
          nextState = SEQ_WAIT;
        end
      end
      SEQ_WAIT: begin
        if (ackDue) begin
          st.commit = 1'b1;
          if (lastBit) nextState = SEQ_IDLE;
        end else begin
          st.tick = 1'b1;
        end
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;
  end

  assign busy    = (state == SEQ_WAIT);
  assign wrReady = !busy;

  // R7
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrValid && wrIsCtrl));

  // R10
  equal_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrValid && wrIsCtrl && !reqDiffers) |=> !busy);

endmodule

// File: rtl/seq_domain_reset.sv
module seq_domain_reset
  import seq_domain_reset_pkg::*;
#(
  parameter int NUM_PARTS   = 2,
  parameter int NUM_DOMAINS = 32,
  parameter int ACK_LAT     = 4,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrValid,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [DATA_W-1:0]                 wrData,
  output logic                              wrReady,
  input  logic [ADDR_W-1:0]                 rdAddr,
  output logic [DATA_W-1:0]                 rdData,
  output logic                              busy,
  output logic [NUM_PARTS*NUM_DOMAINS-1:0]  domainRst
);

  seqStrobes_t st;
  logic wrIsCtrl, reqDiffers, ackDue, lastBit;

  seq_domain_reset_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIsCtrl(wrIsCtrl),
    .reqDiffers(reqDiffers), .ackDue(ackDue), .lastBit(lastBit),
    .st(st), .busy(busy), .wrReady(wrReady)
  );

  seq_domain_reset_dp #(
    .NUM_PARTS(NUM_PARTS), .NUM_DOMAINS(NUM_DOMAINS), .ACK_LAT(ACK_LAT),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wrIsCtrl(wrIsCtrl),
    .reqDiffers(reqDiffers), .ackDue(ackDue), .lastBit(lastBit),
    .domainRst(domainRst)
  );

  // R6
  single_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(domainRst ^ $past(domainRst)) <= 1);

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(domainRst));

endmodule

// File: tb/seq_domain_reset_tb.sv
module seq_domain_reset_tb;

  localparam int NP  = 3;
  localparam int ND  = 8;
  localparam int LAT = 3;
  localparam int AW  = 12;
  localparam int DW  = 32;

  typedef struct {
    int                 cyc;
    logic [NP*ND-1:0]   vec;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic wrReady;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic busy;
  logic [NP*ND-1:0] domainRst;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  item_t expq[$];
  logic [NP*ND-1:0] model = '1;
  logic [NP*ND-1:0] prevRst = '1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seq_domain_reset #(.NUM_PARTS(NP), .NUM_DOMAINS(ND), .ACK_LAT(LAT),
                     .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrReady(wrReady), .rdAddr(rdAddr), .rdData(rdData),
    .busy(busy), .domainRst(domainRst)
  );

  function automatic logic [AW-1:0] ctrlA(input int p);
    return AW'('h40 + 8 * p);
  endfunction
  function automatic logic [AW-1:0] statA(input int p);
    return AW'('h140 + 8 * p);
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every change on domainRst must match the next expected step
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (domainRst !== prevRst) begin
        if (expq.size() == 0) begin
          check(1'b0, "R3 unexpected domain change", 64'(domainRst), 64'(prevRst));
        end else begin
          item_t it;
          it = expq.pop_front();
          check(domainRst === it.vec, "R4 R6 step vector", 64'(domainRst), 64'(it.vec));
          check(cyc == it.cyc, "R5 acknowledge cycle", 64'(cyc), 64'(it.cyc));
        end
      end
      prevRst = domainRst;
    end
  end

  // driver: presents a write, waits for ready, pushes expected steps
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int stalls);
    int c0;
    int k;
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d; stalls = 0;
    while (!wrReady) begin
      @(negedge clk);
      stalls++;
    end
    @(posedge clk);
    #1;
    wrValid = 1'b0;
    c0 = cyc;
    for (int p = 0; p < NP; p++) begin
      if (a == ctrlA(p)) begin
        k = 0;
        for (int i = 0; i < ND; i++) begin
          if (model[p*ND+i] != d[i]) begin
            model[p*ND+i] = d[i];
            k++;
            expq.push_back('{c0 + k * LAT, model});
          end
        end
      end
    end
  endtask

  task automatic drain();
    while (expq.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    logic [DW-1:0] rv;
    int stalls;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", 64'(busy), 0);
    check(wrReady == 1'b1, "R1 ready after reset", 64'(wrReady), 1);
    for (int p = 0; p < NP; p++) begin
      readReg(ctrlA(p), rv);
      check(rv == 32'hFF, "R1 control all ones", 64'(rv), 64'hFF);
      readReg(statA(p), rv);
      check(rv == 32'h1, "R1 status bit0 set", 64'(rv), 1);
    end

    // R4 R5: full release of partition 0, lowest bit first
    doWrite(ctrlA(0), 32'h00, stalls);
    check(busy == 1'b1, "R7 busy during sequence", 64'(busy), 1);
    check(wrReady == 1'b0, "R7 ready low during sequence", 64'(wrReady), 0);
    drain();
    readReg(ctrlA(0), rv);
    check(rv == 32'h00, "R4 partition 0 released", 64'(rv), 0);
    readReg(statA(0), rv);
    check(rv == 32'h0, "R8 status 0 after release", 64'(rv), 0);

    // R8: release only bit 0 of partition 1
    doWrite(ctrlA(1), 32'hFE, stalls);
    readReg(statA(1), rv);
    check(rv == 32'h1, "R8 status still 1 before acknowledge", 64'(rv), 1);
    drain();
    readReg(statA(1), rv);
    check(rv == 32'h0, "R8 status 0 after bit0 release", 64'(rv), 0);
    readReg(ctrlA(1), rv);
    check(rv == 32'hFE, "R3 other bits untouched", 64'(rv), 64'hFE);

    // R7: a held write during a sequence, mixed set and clear steps
    doWrite(ctrlA(2), 32'h5A, stalls);
    doWrite(ctrlA(2), 32'hA5, stalls);
    check(stalls > 0, "R7 write held while busy", 64'(stalls), 1);
    drain();
    readReg(ctrlA(2), rv);
    check(rv == 32'hA5, "R7 held write applied", 64'(rv), 64'hA5);
    readReg(statA(2), rv);
    check(rv == 32'h1, "R8 status follows bit0 set", 64'(rv), 1);

    // R10: equal write
    doWrite(ctrlA(1), 32'hFE, stalls);
    check(stalls == 0, "R10 no stall on equal write", 64'(stalls), 0);
    @(negedge clk);
    check(busy == 1'b0, "R10 busy stays low", 64'(busy), 0);
    repeat (2 * LAT) @(negedge clk);
    check(busy == 1'b0, "R10 still idle", 64'(busy), 0);

    // R2: writes to status and unmapped addresses are ignored
    doWrite(statA(0), 32'hFF, stalls);
    doWrite(AW'('h44), 32'hFF, stalls);
    repeat (2 * LAT) @(negedge clk);
    check(busy == 1'b0, "R2 ignored write leaves idle", 64'(busy), 0);
    readReg(ctrlA(0), rv);
    check(rv == 32'h00, "R2 control unchanged", 64'(rv), 0);
    readReg(AW'('h44), rv);
    check(rv == 32'h0, "R2 unmapped reads zero", 64'(rv), 0);

    // R9: upper write bits dropped; R3 set direction
    doWrite(ctrlA(0), 32'hFFFF_FF01, stalls);
    drain();
    readReg(ctrlA(0), rv);
    check(rv == 32'h01, "R9 upper bits ignored", 64'(rv), 1);
    readReg(statA(0), rv);
    check(rv == 32'h1, "R8 status back to 1", 64'(rv), 1);
    doWrite(ctrlA(0), 32'h81, stalls);
    drain();
    readReg(ctrlA(0), rv);
    check(rv == 32'h81, "R3 bit set again", 64'(rv), 64'h81);

    check(expq.size() == 0, "R4 all steps seen", 64'(expq.size()), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R7 sequence hung actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule